// File: doc/BRIEF.md
# Quadrature Position Tracker with Strobe Latches and Loop Timer

This block turns the two phase signals of an incremental rotary or linear encoder into a signed 16-bit position count and a direction-of-motion flag. Each phase input is first brought into the clock domain and then passed through a digital noise filter with a programmable length. The filter accepts a new level only after the input has held that level for the programmed number of clocks. The filtered pair is decoded at four counts per encoder cycle. A transition in which both phases change at once cannot be assigned a direction, so it is reported and does not move the count.

Two external strobe inputs let outside events, such as a limit switch or a sampling instant, freeze the present count into a capture register of their own. A separate down-counting loop timer runs from its own reload value. It issues a single-cycle tick that paces the position and speed control loops. Software reaches the count, the two captures, the filter length, the timer reload and the direction bit through a flat write/read register port.

Top module: `qei_top`

## Requirements
- R1: After reset the position is 0, `dirUp` is 0, `illegalFlag` and `loopTick` are 0, the filter length register reads 4 and the timer reload register reads 0xFFFF.
- R2: Decoding is four counts per cycle. With the phase pair written {encA,encB}, the forward order is 00, 10, 11, 01, then back to 00. Each filtered move one place forward in this order adds 1 to the position. Each move one place backward subtracts 1.
- R3: A filtered change in which both phases toggle together leaves the position and `dirUp` unchanged and raises `illegalFlag` for exactly one clock.
- R4: `dirUp` is 1 after the most recent valid step was forward and 0 after it was backward.
- R5: The position wraps modulo 2^16: one forward step from 0xFFFF gives 0x0000, and one backward step from 0x0000 gives 0xFFFF.
- R6: A filter of length N (1 to 15; a programmed 0 acts as 1) accepts a new input level only after it has been seen for N consecutive clocks. A pulse held for N-1 clocks is discarded. A pulse held for exactly N clocks is accepted.
- R7: A rising edge on `strobeIn0` copies the present position into capture 0, and a rising edge on `strobeIn1` copies it into capture 1. Each capture changes only on its own strobe's rising edge, and a strobe held high captures only once.
- R8: The loop timer issues a one-clock `loopTick` every reload+1 clocks, and a reload of 0 gives a tick on every clock. Writing the reload register stores the value and restarts the countdown from it.
- R9: Register port, where `addr` selects: 0 = position (read/write; a write presets the count and takes priority over a step in the same clock), 1 = capture 0 (read only), 2 = capture 1 (read only), 3 = filter length in bits 3:0, 4 = timer reload, 5 = status with bit 0 = `dirUp`. Unused addresses read 0, and writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the filter sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| strobeIn0 | input | 1 | Capture request 0, asynchronous, rising edge |
| strobeIn1 | input | 1 | Capture request 1, asynchronous, rising edge |
| wrEn | input | 1 | Register write enable |
| addr | input | 3 | Register select |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for `addr`, combinational |
| position | output | 16 | Current position count |
| dirUp | output | 1 | Direction of the last valid step, 1 = forward |
| illegalFlag | output | 1 | One-clock flag for a double-phase transition |
| loopTick | output | 1 | One-clock loop timer tick |

## Verification
The step-size and direction properties assume that the filtered phases move at most one place per clock. This holds only if each raw phase level is held longer than the filter length plus the synchronizer delay. The stimulus therefore holds every encoder state for at least the filter length plus six clocks. Every deliberate glitch it injects is shorter than the filter length, so the filter is expected to discard it. The only exception is the single directed test at the acceptance boundary. The tick-spacing property assumes that no reload write lands on the tick clock while a reload of zero is active, and the bench writes the reload only between measurements.

// File: rtl/qei_pkg.sv
`timescale 1ns/1ps
package qei_pkg;

  // Register select codes on the flat access port.
  localparam logic [2:0] ADDR_COUNT  = 3'd0;
  localparam logic [2:0] ADDR_CAP0   = 3'd1;
  localparam logic [2:0] ADDR_CAP1   = 3'd2;
  localparam logic [2:0] ADDR_FILT   = 3'd3;
  localparam logic [2:0] ADDR_RELOAD = 3'd4;
  localparam logic [2:0] ADDR_STATUS = 3'd5;

  localparam int NUM_STROBES = 2;

  // Strobes from the decode control into the datapath.
  typedef struct packed {
    logic                   stepUp;
    logic                   stepDn;
    logic                   badStep;
    logic [NUM_STROBES-1:0] grab;
  } qeiCtl_t;

  // Position of a phase pair {a,b} in the forward sequence 00,10,11,01.
  function automatic logic [1:0] phaseOf(input logic a, input logic b);
    logic [1:0] ph;
    case ({a, b})
      2'b00:   ph = 2'd0;
      2'b10:   ph = 2'd1;
      2'b11:   ph = 2'd2;
      default: ph = 2'd3;
    endcase
    return ph;
  endfunction

endpackage

// File: rtl/qei_sync.sv
`timescale 1ns/1ps
module qei_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qei_filter.sv
`timescale 1ns/1ps
module qei_filter #(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [LEN_W-1:0] lenCfg,
  output logic             level
);
  localparam int RUN_W = LEN_W + 1;

  logic             syncd;
  logic [LEN_W-1:0] runLen;
  logic [LEN_W-1:0] effLen;
  logic [RUN_W-1:0] nextRun;

  qei_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncd)
  );

  // A programmed length of zero behaves as one.
  assign effLen  = (lenCfg == '0) ? LEN_W'(1) : lenCfg;
  assign nextRun = {1'b0, runLen} + RUN_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= 1'b0;
      runLen <= '0;
    end else if (syncd == level) begin
      runLen <= '0;
    end else if (nextRun >= {1'b0, effLen}) begin
      level  <= syncd;
      runLen <= '0;
    end else begin
      runLen <= nextRun[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/qei_ctrl.sv
`timescale 1ns/1ps
module qei_ctrl
  import qei_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   levA,
  input  logic                   levB,
  input  logic [NUM_STROBES-1:0] strobeSync,
  output qeiCtl_t                ctl
);
  logic                   prevA;
  logic                   prevB;
  logic [NUM_STROBES-1:0] prevStrobe;
  logic [1:0]             curPh;
  logic [1:0]             oldPh;
  logic [1:0]             delta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA      <= 1'b0;
      prevB      <= 1'b0;
      prevStrobe <= '0;
    end else begin
      prevA      <= levA;
      prevB      <= levB;
      prevStrobe <= strobeSync;
    end
  end

  assign curPh = phaseOf(levA, levB);
  assign oldPh = phaseOf(prevA, prevB);
  assign delta = curPh - oldPh;

  always_comb begin
    ctl.stepUp  = (delta == 2'd1);
    ctl.stepDn  = (delta == 2'd3);
    ctl.badStep = (delta == 2'd2);
    ctl.grab    = strobeSync & ~prevStrobe;
  end
endmodule

// File: rtl/qei_datapath.sv
`timescale 1ns/1ps
module qei_datapath
  import qei_pkg::*;
#(
  parameter int              DATA_W       = 16,
  parameter int              CNT_W        = 16,
  parameter int              TMR_W        = 16,
  parameter int              LEN_W        = 4,
  parameter logic [LEN_W-1:0] FILT_RESET  = 4'd4,
  parameter logic [TMR_W-1:0] RELOAD_RESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  qeiCtl_t           ctl,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  position,
  output logic              dirUp,
  output logic              illegalFlag,
  output logic              loopTick,
  output logic [LEN_W-1:0]  lenCfg,
  output logic [TMR_W-1:0]  reloadCfg
);
  logic [CNT_W-1:0] capQ [NUM_STROBES];
  logic [TMR_W-1:0] timerQ;
  logic             cntWr;
  logic             reloadWr;

  assign cntWr    = wrEn && (addr == ADDR_COUNT);
  assign reloadWr = wrEn && (addr == ADDR_RELOAD);

  // Position counter and direction.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      position    <= '0;
      dirUp       <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      illegalFlag <= ctl.badStep;
      if (cntWr)           position <= wrData[CNT_W-1:0];
      else if (ctl.stepUp) position <= position + CNT_W'(1);
      else if (ctl.stepDn) position <= position - CNT_W'(1);
      if (ctl.stepUp)      dirUp <= 1'b1;
      else if (ctl.stepDn) dirUp <= 1'b0;
    end
  end

  // One capture register per strobe.
  genvar g;
  generate
    for (g = 0; g < NUM_STROBES; g++) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rstN)           capQ[g] <= '0;
        else if (ctl.grab[g]) capQ[g] <= position;
      end
    end
  endgenerate

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCfg    <= FILT_RESET;
      reloadCfg <= RELOAD_RESET;
    end else if (wrEn) begin
      if (addr == ADDR_FILT) lenCfg    <= wrData[LEN_W-1:0];
      if (reloadWr)          reloadCfg <= wrData[TMR_W-1:0];
    end
  end

  // Loop timer: counts down, ticks on zero, reloads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ   <= RELOAD_RESET;
      loopTick <= 1'b0;
    end else if (reloadWr) begin
      timerQ   <= wrData[TMR_W-1:0];
      loopTick <= 1'b0;
    end else if (timerQ == '0) begin
      timerQ   <= reloadCfg;
      loopTick <= 1'b1;
    end else begin
      timerQ   <= timerQ - TMR_W'(1);
      loopTick <= 1'b0;
    end
  end

  // Read multiplexer.
  always_comb begin
    case (addr)
      ADDR_COUNT:  rdData = DATA_W'(position);
      ADDR_CAP0:   rdData = DATA_W'(capQ[0]);
      ADDR_CAP1:   rdData = DATA_W'(capQ[1]);
      ADDR_FILT:   rdData = DATA_W'(lenCfg);
      ADDR_RELOAD: rdData = DATA_W'(reloadCfg);
      ADDR_STATUS: rdData = DATA_W'(dirUp);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/qei_top.sv
`timescale 1ns/1ps
module qei_top
  import qei_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int TMR_W       = 16,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic              strobeIn0,
  input  logic              strobeIn1,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  position,
  output logic              dirUp,
  output logic              illegalFlag,
  output logic              loopTick
);
  localparam int NUM_PHASES = 2;

  logic [NUM_PHASES-1:0]  encRaw;
  logic [NUM_PHASES-1:0]  encLevel;
  logic [NUM_STROBES-1:0] strobeRaw;
  logic [NUM_STROBES-1:0] strobeSync;
  logic [LEN_W-1:0]       lenCfg;
  logic [TMR_W-1:0]       reloadCfg;
  qeiCtl_t                ctl;

  assign encRaw    = {encB, encA};
  assign strobeRaw = {strobeIn1, strobeIn0};

  genvar p;
  generate
    for (p = 0; p < NUM_PHASES; p++) begin : g_filt
      qei_filter #(.LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk   (clk),
        .rstN  (rstN),
        .rawIn (encRaw[p]),
        .lenCfg(lenCfg),
        .level (encLevel[p])
      );
    end
    for (p = 0; p < NUM_STROBES; p++) begin : g_strb
      qei_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .din (strobeRaw[p]),
        .dout(strobeSync[p])
      );
    end
  endgenerate

  qei_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .levA      (encLevel[0]),
    .levB      (encLevel[1]),
    .strobeSync(strobeSync),
    .ctl       (ctl)
  );

  qei_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .TMR_W(TMR_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .position   (position),
    .dirUp      (dirUp),
    .illegalFlag(illegalFlag),
    .loopTick   (loopTick),
    .lenCfg     (lenCfg),
    .reloadCfg  (reloadCfg)
  );
endmodule

// File: rtl/qei_checker.sv
`timescale 1ns/1ps
module qei_checker
  import qei_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [CNT_W-1:0]  position,
  input logic              dirUp,
  input logic              illegalFlag,
  input logic              loopTick,
  input logic [TMR_W-1:0]  reloadCfg
);
  logic cntWr;
  assign cntWr = wrEn && (addr == ADDR_COUNT);

  assert_step_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (position == $past(position) ||
                position == $past(position) + CNT_W'(1) ||
                position == $past(position) - CNT_W'(1)));

  assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (illegalFlag && !$past(cntWr)) |-> position == $past(position));

  assert_dir_fwd_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr ##1 (position == $past(position) + CNT_W'(1)) |-> dirUp);

  assert_dir_back_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr ##1 (position == $past(position) - CNT_W'(1)) |-> !dirUp);

  assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loopTick && reloadCfg != '0) |=> !loopTick);

  assert_count_preset_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> position == $past(wrData[CNT_W-1:0]));
endmodule

bind qei_top qei_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .position   (position),
  .dirUp      (dirUp),
  .illegalFlag(illegalFlag),
  .loopTick   (loopTick),
  .reloadCfg  (reloadCfg)
);

// File: tb/tb_qei_top.sv
`timescale 1ns/1ps
module tb_qei_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encA = 1'b0, encB = 1'b0;
  logic        strobeIn0 = 1'b0, strobeIn1 = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData, position;
  logic        dirUp, illegalFlag, loopTick;

  int compared = 0;
  int mismatched = 0;
  int illegalSeen = 0;
  int illegalSent = 0;

  logic [15:0] expCount = 16'd0;
  logic        expDir = 1'b0;
  logic [1:0]  curPh = 2'd0;
  int          filtLen = 4;

  always #5 clk = ~clk;

  qei_top dut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .strobeIn0(strobeIn0), .strobeIn1(strobeIn1),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .position(position), .dirUp(dirUp), .illegalFlag(illegalFlag),
    .loopTick(loopTick)
  );

  always @(negedge clk) if (rstN && illegalFlag) illegalSeen++;

  // Phase index -> {A,B} per the forward order 00,10,11,01.
  function automatic logic [1:0] abOf(input logic [1:0] ph);
    case (ph)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Move the encoder to phase ph, update the model, let it settle.
  task automatic moveTo(input logic [1:0] ph, input int hold);
    logic [1:0] d;
    logic [1:0] ab;
    d = ph - curPh;
    if (d == 2'd1) begin expCount = expCount + 16'd1; expDir = 1'b1; end
    else if (d == 2'd3) begin expCount = expCount - 16'd1; expDir = 1'b0; end
    else if (d == 2'd2) illegalSent++;
    curPh = ph;
    ab = abOf(ph);
    @(negedge clk); encA = ab[1]; encB = ab[0];
    waitCycles(hold);
  endtask

  initial begin
    logic [15:0] rd;
    logic [15:0] cap0;
    int gap;
    void'($urandom(32'd4242));
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 position", position, 16'd0);
    check("R1 dirUp", {15'd0, dirUp}, 16'd0);
    check("R1 illegalFlag", {15'd0, illegalFlag}, 16'd0);
    check("R1 loopTick", {15'd0, loopTick}, 16'd0);
    regRead(3'd3, rd); check("R1 filter length", rd, 16'd4);
    regRead(3'd4, rd); check("R1 reload", rd, 16'hFFFF);

    // R2 / R4 directed forward and backward
    filtLen = 3; regWrite(3'd3, 16'd3);
    for (int i = 0; i < 5; i++) moveTo(curPh + 2'd1, 20);
    check("R2 forward count", position, expCount);
    check("R4 dir forward", {15'd0, dirUp}, 16'd1);
    for (int i = 0; i < 7; i++) moveTo(curPh - 2'd1, 20);
    check("R2 backward count", position, expCount);
    check("R4 dir backward", {15'd0, dirUp}, 16'd0);
    regRead(3'd5, rd); check("R9 status dir", rd, {15'd0, expDir});

    // R3 illegal double transition
    gap = illegalSeen;
    moveTo(curPh + 2'd2, 20);
    check("R3 count held", position, expCount);
    check("R3 dir held", {15'd0, dirUp}, {15'd0, expDir});
    check("R3 one flag pulse", 16'(illegalSeen - gap), 16'd1);

    // R5 wrap both ways
    regWrite(3'd0, 16'hFFFF); expCount = 16'hFFFF;
    moveTo(curPh + 2'd1, 20);
    check("R5 wrap up", position, 16'h0000);
    regWrite(3'd0, 16'h0000); expCount = 16'h0000;
    moveTo(curPh - 2'd1, 20);
    check("R5 wrap down", position, 16'hFFFF);

    // R6 filter boundary, length 5, from phase 0 with a forward last step
    filtLen = 5; regWrite(3'd3, 16'd5);
    while (curPh != 2'd3) moveTo(curPh + 2'd1, 24);
    moveTo(2'd0, 24);
    check("R6 setup dir", {15'd0, dirUp}, 16'd1);
    @(negedge clk); encA = 1'b1; waitCycles(filtLen - 1); encA = 1'b0;
    waitCycles(24);
    check("R6 short pulse count", position, expCount);
    check("R6 short pulse dir", {15'd0, dirUp}, 16'd1);
    @(negedge clk); encA = 1'b1; waitCycles(filtLen); encA = 1'b0;
    waitCycles(24);
    expDir = 1'b0;
    check("R6 full pulse count", position, expCount);
    check("R6 full pulse dir", {15'd0, dirUp}, 16'd0);

    // R7 strobe captures
    regWrite(3'd0, 16'h1234); expCount = 16'h1234;
    @(negedge clk); strobeIn0 = 1'b1; waitCycles(6);
    regRead(3'd1, rd); check("R7 capture0", rd, 16'h1234);
    regRead(3'd2, rd); check("R7 capture1 untouched", rd, 16'h0000);
    moveTo(curPh + 2'd1, 24);
    @(negedge clk); strobeIn1 = 1'b1; waitCycles(6);
    regRead(3'd2, rd); check("R7 capture1", rd, expCount);
    regRead(3'd1, rd); check("R7 held strobe no recapture", rd, 16'h1234);
    @(negedge clk); strobeIn0 = 1'b0; waitCycles(6);
    @(negedge clk); strobeIn0 = 1'b1; waitCycles(6);
    regRead(3'd1, rd); check("R7 capture0 again", rd, expCount);
    cap0 = rd;

    // R9 read-only write ignored, unused address
    regWrite(3'd1, 16'hBEEF);
    regRead(3'd1, rd); check("R9 read-only write", rd, cap0);
    regRead(3'd7, rd); check("R9 unused address", rd, 16'd0);

    // R8 loop timer
    regWrite(3'd4, 16'd9);
    regRead(3'd4, rd); check("R8 reload readback", rd, 16'd9);
    while (!loopTick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!loopTick && gap < 100);
    check("R8 period reload 9", 16'(gap), 16'd10);
    @(negedge clk);
    check("R8 tick one cycle", {15'd0, loopTick}, 16'd0);
    regWrite(3'd4, 16'd37);
    while (!loopTick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!loopTick && gap < 100);
    check("R8 period reload 37", 16'(gap), 16'd38);
    regWrite(3'd4, 16'd0);
    waitCycles(2);
    for (int i = 0; i < 3; i++) begin
      check("R8 reload zero ticks each clock", {15'd0, loopTick}, 16'd1);
      @(negedge clk);
    end
    regWrite(3'd4, 16'hFFFF);

    // Random walk with glitches and illegal jumps (R2 R3 R4 R6)
    filtLen = 3; regWrite(3'd3, 16'd3);
    gap = illegalSeen; illegalSent = 0;
    for (int i = 0; i < 250; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) begin
        int w;
        w = $urandom_range(1, filtLen - 1);
        @(negedge clk); encB = ~encB; waitCycles(w); encB = ~encB;
        waitCycles(4);
      end
      if (r == 0)      moveTo(curPh + 2'd2, $urandom_range(filtLen + 6, 24));
      else if (r < 6)  moveTo(curPh + 2'd1, $urandom_range(filtLen + 6, 24));
      else             moveTo(curPh - 2'd1, $urandom_range(filtLen + 6, 24));
      if (i % 50 == 49) begin
        check("R2 random walk count", position, expCount);
        check("R4 random walk dir", {15'd0, dirUp}, {15'd0, expDir});
      end
    end
    check("R3 random illegal pulses", 16'(illegalSeen - gap), 16'(illegalSent));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule